// File: doc/BRIEF.md
# Glitch-Free Clock Output Enable Controller

This block governs one clock output channel of a multi-output clock generator. It decides whether the channel is active. The decision comes from either an external enable pin or a register bit, and an override bit picks between the two. The pin is synchronized into the clock domain before use. While the pin is in control, the register's enable bit reads back the synchronized pin state.

When the channel becomes enabled, the pad drivers turn on and hold the output at its low idle level for a programmable number of settle cycles. Only then does the clock start to pass, and the first high phase is a whole one. When the channel becomes disabled, the gate closes during a low phase. The output rests low for a programmable number of cycles and then both pad drivers release to high impedance.

A 2-bit format field sets the pad mode. In single-ended mode the complementary pin stays in high impedance. In the three differential modes the complementary pin is driven with the inverted clock whenever the channel drives.

Top module: `clkout_enable_ctrl`

## Requirements
- R1: After reset the override bit is 0, the format field holds its reset value (default 01), both pad enables are low and the positive clock pin is low.
- R2: With override 0, read bit 0 shows the external pin delayed by two clock edges, and a written value for bit 0 is ignored.
- R3: With override 1, the pin is ignored and read bit 0 shows the written enable bit. The channel is enabled only when both override and this bit are 1.
- R4: Let L be the edge count after a stimulus at which the effective enable changes: L=1 for a register write and L=2 for the pin. The pads drive from edge L+1, and the first high phase follows edge L+SETTLE_CYCLES+2. The output stays low before that.
- R5: Every high phase of the positive clock pin lasts the whole high phase of the input clock; no runt pulse appears.
- R6: After enable falls (same L), the last high phase follows edge L+1. The output then stays low and driven, and both pad enables drop from edge L+STOP_CYCLES+1.
- R7: If enable falls during the settle wait, even at its last cycle, no pulse appears and the pads release at edge L+1. A later enable restarts the full wait.
- R8: Format 00 is single-ended: the complementary pad enable stays low. Formats 01, 10 and 11 are differential: the complementary pad enable equals the positive one, and the complementary pin is the inverse of the positive pin.
- R9: Register layout: bit 0 is the enable, bit 1 is the override, bits 3:2 are the format. A write sets the override and format, and read bits 3:1 return them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock to be gated |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_pin_i | input | 1 | External enable pin, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data |
| clk_p_o | output | 1 | Gated clock, positive pin |
| clk_n_o | output | 1 | Gated clock, complementary pin |
| clk_p_oe_o | output | 1 | Positive pad drive enable |
| clk_n_oe_o | output | 1 | Complementary pad drive enable |

## Verification
Several rules are checked on every cycle by assertions. The gate is never open while the pads are released. Release happens only with the gate closed. A settle abort always lands in the idle state, and the run state is entered only from the settle state. Single-ended mode never drives the complementary pin. The register's enable copy tracks the pin or holds still, depending on the override. Some behaviour only the bench scenarios can show: the exact edge of the first and last pulse and of the pad release, the width of every high phase seen at the pin, and the restart of the full wait after an abort at the last settle cycle.

// File: rtl/coe_pkg.sv
package coe_pkg;
   localparam int CTRL_W      = 4;
   localparam int BIT_EN      = 0;
   localparam int BIT_OVR     = 1;
   localparam int BIT_FMT_LO  = 2;
   localparam int BIT_FMT_HI  = 3;

   typedef enum logic [1:0] {
      FMT_CMOS   = 2'b00,
      FMT_LVDS   = 2'b01,
      FMT_LVPECL = 2'b10,
      FMT_HCSL   = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      SQ_OFF    = 2'd0,
      SQ_SETTLE = 2'd1,
      SQ_RUN    = 2'd2,
      SQ_STOP   = 2'd3
   } sq_e;
endpackage

// File: rtl/coe_sync.sv
module coe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("coe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/coe_regs.sv
module coe_regs
   import coe_pkg::*;
#(
   parameter fmt_e FMT_RST = FMT_LVDS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [CTRL_W-1:0] wdata_i,
   input  logic              pin_s_i,
   output logic [CTRL_W-1:0] rdata_o,
   output logic              en_eff_o,
   output fmt_e              fmt_o
);
   logic ovr_q, en_q, ovr_nx, rb_en;
   fmt_e fmt_q;

   assign ovr_nx = we_i ? wdata_i[BIT_OVR] : ovr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovr_q <= 1'b0;
         en_q  <= 1'b0;
         fmt_q <= FMT_RST;
      end else begin
         ovr_q <= ovr_nx;
         if (!ovr_nx)   en_q <= pin_s_i;
         else if (we_i) en_q <= wdata_i[BIT_EN];
         if (we_i) fmt_q <= fmt_e'(wdata_i[BIT_FMT_HI:BIT_FMT_LO]);
      end
   end

   assign rb_en    = ovr_q ? en_q : pin_s_i;
   assign en_eff_o = ovr_q ? (ovr_q & en_q) : pin_s_i;
   assign fmt_o    = fmt_q;
   assign rdata_o  = {fmt_q, ovr_q, rb_en};

   // R2: without override the stored bit follows the synchronized pin
   a_r2_copy_tracks_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ovr_q && !we_i) |=> (en_q == $past(pin_s_i)));

   // R3: with override the stored bit only changes by a write
   a_r3_pin_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovr_q && !we_i) |=> $stable(en_q));
endmodule

// File: rtl/coe_seq.sv
module coe_seq
   import coe_pkg::*;
#(
   parameter int SETTLE_CYCLES = 400,
   parameter int STOP_CYCLES   = 2,
   parameter bit GATE_LATCH    = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic drive_o,
   output logic gate_o
);
   localparam int CNT_MAX = (SETTLE_CYCLES > STOP_CYCLES) ? SETTLE_CYCLES : STOP_CYCLES;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
   localparam logic [CW-1:0] STOP_LAST   = CW'(STOP_CYCLES - 1);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("coe_seq: SETTLE_CYCLES must be at least 1");
   end
   if (STOP_CYCLES < 2) begin : g_bad_stop
      $error("coe_seq: STOP_CYCLES must be at least 2");
   end

   sq_e           state_q;
   logic [CW-1:0] cnt_q;
   logic          run;
   logic          gate_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SQ_OFF;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SQ_OFF: begin
               if (en_i) begin
                  state_q <= SQ_SETTLE;
                  cnt_q   <= '0;
               end
            end
            SQ_SETTLE: begin
               if (!en_i)                    state_q <= SQ_OFF;
               else if (cnt_q == SETTLE_LAST) state_q <= SQ_RUN;
               else                          cnt_q   <= cnt_q + 1'b1;
            end
            SQ_RUN: begin
               if (!en_i) begin
                  state_q <= SQ_STOP;
                  cnt_q   <= '0;
               end
            end
            SQ_STOP: begin
               if (cnt_q == STOP_LAST) state_q <= SQ_OFF;
               else                    cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= SQ_OFF;
         endcase
      end
   end

   assign run = (state_q == SQ_RUN);

   // gate may only change while the clock is low
   if (GATE_LATCH) begin : g_gate_latch
      always_latch begin
         if (!clk_i) gate_q <= run;
      end
   end else begin : g_gate_negedge
      always_ff @(negedge clk_i or negedge rst_ni) begin
         if (!rst_ni) gate_q <= 1'b0;
         else         gate_q <= run;
      end
   end

   assign gate_o  = gate_q;
   assign drive_o = (state_q != SQ_OFF);

   // R6: idle state never has an open gate
   a_r6_gate_closed_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SQ_OFF) |-> !gate_q);

   // R6: pads release only after the gate has closed
   a_r6_release_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(drive_o) |-> !gate_q);

   // R7: enable loss during settle returns to idle
   a_r7_settle_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SQ_SETTLE && !en_i) |=> (state_q == SQ_OFF));

   // R4: running is reached only through the settle wait
   a_r4_run_after_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(state_q == SQ_RUN) |-> ($past(state_q) == SQ_SETTLE));
endmodule

// File: rtl/clkout_enable_ctrl.sv
module clkout_enable_ctrl
   import coe_pkg::*;
#(
   parameter int   SYNC_STAGES   = 2,
   parameter int   SETTLE_CYCLES = 400,
   parameter int   STOP_CYCLES   = 2,
   parameter bit   GATE_LATCH    = 1'b0,
   parameter fmt_e FMT_RST       = FMT_LVDS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_pin_i,
   input  logic              reg_we_i,
   input  logic [CTRL_W-1:0] reg_wdata_i,
   output logic [CTRL_W-1:0] reg_rdata_o,
   output logic              clk_p_o,
   output logic              clk_n_o,
   output logic              clk_p_oe_o,
   output logic              clk_n_oe_o
);
   logic pin_s, en_eff, drive, gate;
   fmt_e fmt;

   coe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (en_pin_i),
      .q_o   (pin_s)
   );

   coe_regs #(.FMT_RST(FMT_RST)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (reg_we_i),
      .wdata_i (reg_wdata_i),
      .pin_s_i (pin_s),
      .rdata_o (reg_rdata_o),
      .en_eff_o(en_eff),
      .fmt_o   (fmt)
   );

   coe_seq #(
      .SETTLE_CYCLES(SETTLE_CYCLES),
      .STOP_CYCLES  (STOP_CYCLES),
      .GATE_LATCH   (GATE_LATCH)
   ) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_eff),
      .drive_o(drive),
      .gate_o (gate)
   );

   assign clk_p_o    = clk_i & gate;
   assign clk_n_o    = ~clk_p_o;
   assign clk_p_oe_o = drive;
   assign clk_n_oe_o = drive & (fmt != FMT_CMOS);

   // R8: single-ended mode never drives the complementary pin
   a_r8_cmos_neg_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fmt == FMT_CMOS) |-> !clk_n_oe_o);

   // R5: an open gate always has the pad driven
   a_r5_gate_needs_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate |-> clk_p_oe_o);
endmodule

// File: tb/clkout_enable_ctrl_tb.sv
`timescale 1ns/1ps
module clkout_enable_ctrl_tb;
   localparam int S    = 12;
   localparam int STOP = 3;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       pin;
   logic       we;
   logic [3:0] wdata;
   logic [3:0] rdata;
   logic       cp, cn, poe, noe;

   int n_chk  = 0;
   int n_fail = 0;

   logic sa_p, sb_p, sa_n, sb_n, s_poe, s_noe;
   logic [3:0] s_rd;

   always #2.5 clk = ~clk;

   clkout_enable_ctrl #(
      .SETTLE_CYCLES(S),
      .STOP_CYCLES  (STOP)
   ) u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .en_pin_i   (pin),
      .reg_we_i   (we),
      .reg_wdata_i(wdata),
      .reg_rdata_o(rdata),
      .clk_p_o    (cp),
      .clk_n_o    (cn),
      .clk_p_oe_o (poe),
      .clk_n_oe_o (noe)
   );

   function automatic int f_drive_from(int l);   return l + 1;         endfunction
   function automatic int f_first_pulse(int l);  return l + S + 2;     endfunction
   function automatic int f_last_pulse(int l);   return l + 1;         endfunction
   function automatic int f_release(int l);      return l + STOP + 1;  endfunction
   function automatic logic [3:0] f_ctrl(logic [1:0] fm, logic ov, logic en);
      return {fm, ov, en};
   endfunction

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // edge, sample early high, sample late high, return in low phase
   task automatic tick();
      @(posedge clk);
      #1;
      sa_p = cp; sa_n = cn; s_poe = poe; s_noe = noe; s_rd = rdata;
      #1;
      sb_p = cp; sb_n = cn;
      #1;
      we = 1'b0;
   endtask

   task automatic set_wr(input logic [3:0] d);
      we = 1'b1; wdata = d;
   endtask

   task automatic obs_on(input int l, input string req);
      for (int k = 1; k <= f_first_pulse(l) + 2; k++) begin
         tick();
         chk(s_poe == (k >= f_drive_from(l)), req, s_poe, k >= f_drive_from(l));
         chk(sa_p == (k >= f_first_pulse(l)), req, sa_p, k >= f_first_pulse(l));
         chk(sb_p == sa_p, "R5", sb_p, sa_p);
      end
   endtask

   task automatic obs_off(input int l, input string req);
      for (int k = 1; k <= f_release(l) + 2; k++) begin
         tick();
         chk(sa_p == (k <= f_last_pulse(l)), req, sa_p, k <= f_last_pulse(l));
         chk(s_poe == (k < f_release(l)), req, s_poe, k < f_release(l));
         chk(sb_p == sa_p, "R5", sb_p, sa_p);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic h1, h2;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; pin = 1'b0; we = 1'b0; wdata = 4'h0;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk(s_poe == 1'b0 && s_noe == 1'b0, "R1", {s_poe, s_noe}, 0);
         chk(sa_p == 1'b0, "R1", sa_p, 0);
         chk(s_rd[1] == 1'b0, "R1", s_rd[1], 0);
         chk(s_rd[3:2] == 2'b01, "R9", s_rd[3:2], 1);
      end
      rst_n = 1'b1;
      tick();

      // R2 readback latency, R4 pin path
      pin = 1'b1;
      tick(); chk(s_rd[0] == 1'b0, "R2", s_rd[0], 0); chk(s_poe == 1'b0, "R4", s_poe, 0);
      tick(); chk(s_rd[0] == 1'b1, "R2", s_rd[0], 1); chk(s_poe == 1'b0, "R4", s_poe, 0);
      for (int k = 3; k <= f_first_pulse(2) + 2; k++) begin
         tick();
         chk(s_poe == 1'b1, "R4", s_poe, 1);
         chk(sa_p == (k >= f_first_pulse(2)), "R4", sa_p, k >= f_first_pulse(2));
         chk(sb_p == sa_p, "R5", sb_p, sa_p);
         chk(s_noe == 1'b1 && sa_n == ~sa_p && sb_n == ~sb_p, "R8", {s_noe, sa_n}, {1'b1, ~sa_p});
      end

      // R2 write of enable ignored while pin controls
      pin = 1'b0;
      set_wr(f_ctrl(2'b01, 1'b0, 1'b1));
      obs_off(2, "R6");
      for (int k = 0; k < 6; k++) begin
         tick();
         chk(s_rd[0] == 1'b0, "R2", s_rd[0], 0);
         chk(sa_p == 1'b0, "R2", sa_p, 0);
      end

      // R3 override, register path
      set_wr(f_ctrl(2'b01, 1'b1, 1'b1));
      obs_on(1, "R4");
      for (int k = 0; k < 20; k++) begin
         pin = k[0];
         tick();
         chk(sa_p == 1'b1 && s_rd[0] == 1'b1, "R3", {sa_p, s_rd[0]}, 3);
      end
      set_wr(f_ctrl(2'b01, 1'b1, 1'b0));
      obs_off(1, "R6");
      pin = 1'b1;
      for (int k = 0; k < 20; k++) begin
         tick();
         chk(sa_p == 1'b0 && s_poe == 1'b0 && s_rd[0] == 1'b0, "R3", {sa_p, s_poe, s_rd[0]}, 0);
      end

      // R7 early abort
      set_wr(f_ctrl(2'b01, 1'b1, 1'b1));
      for (int k = 0; k < 4; k++) tick();
      set_wr(f_ctrl(2'b01, 1'b1, 1'b0));
      tick(); chk(s_poe == 1'b1, "R7", s_poe, 1);
      for (int k = 2; k < 12; k++) begin
         tick();
         chk(s_poe == 1'b0 && sa_p == 1'b0, "R7", {s_poe, sa_p}, 0);
      end
      // R7 abort at the last settle cycle
      set_wr(f_ctrl(2'b01, 1'b1, 1'b1));
      tick();
      for (int k = 0; k < S - 1; k++) tick();
      set_wr(f_ctrl(2'b01, 1'b1, 1'b0));
      tick(); chk(sa_p == 1'b0, "R7", sa_p, 0);
      for (int k = 2; k < 10; k++) begin
         tick();
         chk(s_poe == 1'b0 && sa_p == 1'b0, "R7", {s_poe, sa_p}, 0);
      end
      set_wr(f_ctrl(2'b01, 1'b1, 1'b1));
      obs_on(1, "R7");

      // R8 / R9 formats while running
      for (int m = 0; m < 4; m++) begin
         set_wr(f_ctrl(m[1:0], 1'b1, 1'b1));
         tick();
         tick();
         chk(s_rd == f_ctrl(m[1:0], 1'b1, 1'b1), "R9", s_rd, f_ctrl(m[1:0], 1'b1, 1'b1));
         chk(s_poe == 1'b1 && sa_p == 1'b1, "R8", {s_poe, sa_p}, 3);
         chk(s_noe == (m != 0), "R8", s_noe, m != 0);
         if (m != 0) chk(sa_n == ~sa_p && sb_n == ~sb_p, "R8", sa_n, ~sa_p);
      end

      // random pin activity under pin control
      set_wr(f_ctrl(2'($urandom_range(1, 3)), 1'b0, 1'b0));
      pin = 1'b0;
      tick(); tick();
      h1 = pin; h2 = pin;
      for (int seg = 0; seg < 120; seg++) begin
         int len;
         pin = 1'($urandom_range(0, 1));
         len = $urandom_range(1, S + 6);
         for (int k = 0; k < len; k++) begin
            tick();
            h2 = h1; h1 = pin;
            chk(s_rd[0] == h2, "R2", s_rd[0], h2);
            chk(sb_p == sa_p, "R5", sb_p, sa_p);
            chk(!sa_p || s_poe, "R5", s_poe, 1);
            chk(s_noe == s_poe, "R8", s_noe, s_poe);
         end
      end
      pin = 1'b1;
      for (int k = 0; k < S + 8; k++) tick();
      chk(sa_p == 1'b1 && sb_p == 1'b1, "R4", sa_p, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule